// File: doc/BRIEF.md
# Floating-Point Issue Hazard Gate

This block sits at the decode-to-execute boundary of an in-order pipeline. The pipeline has one integer path and four floating-point writers: a load, a pipelined adder, a pipelined multiplier and a divider that is not pipelined. Each cycle the gate looks at the decoded instruction's unit code, destination register and two source registers. It then raises either `issue` or `stall` for that instruction.

Three pieces of state make the decision. The first is a per-register countdown of cycles until a pending floating-point result can be consumed. The second is a shift register that books the single floating-point write-back port ahead of time. The third is a busy counter for the divider. A stalled instruction changes none of this state, so decode can simply present the same instruction again in the next cycle.

Top module: `hzd_issue_gate`

## Requirements
- R1: When `dec_valid` is low, both `issue` and `stall` are low. When it is high, exactly one of them is high, and `issue` is high only if no hazard of R3 to R6 applies.
- R2: Unit codes are as follows. 0 is integer (no floating-point sources, no floating-point write, never stalls). 1 is floating-point load (writes `dec_dst` with latency 1, no floating-point sources). 2 is add (latency 3). 3 is multiply (latency 6). 4 is divide (latency 23). Codes 5 to 7 behave like code 0. Codes 2 to 4 read both `dec_src_a` and `dec_src_b` and write `dec_dst`.
- R3: Read-after-write: a code 2 to 4 instruction stalls while either source has a pending write. A consumer of a producer issued in cycle t with latency L can issue in cycle t+L+1 at the earliest.
- R4: After a divide issues in cycle t, another divide stalls in cycles t+1 to t+23 and may issue in cycle t+24.
- R5: A writer issued in cycle t with latency L owns the write port in cycle t+L. A later writer whose own t+L falls in an owned cycle stalls.
- R6: Write-after-write: a writer stalls while an earlier in-flight write to the same destination completes in the same cycle as its own write-back slot, or later.
- R7: Adds and multiplies accept one instruction per cycle back to back when no other hazard applies.
- R8: Right after reset nothing is pending, and any valid instruction issues.
- R9: A stalled instruction books no port slot, sets no pending write and does not start the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decoded instruction present |
| dec_unit | input | 3 | Unit code (R2) |
| dec_dst | input | 5 | Destination floating-point register |
| dec_src_a | input | 5 | First source floating-point register |
| dec_src_b | input | 5 | Second source floating-point register |
| issue | output | 1 | Instruction leaves decode this cycle |
| stall | output | 1 | Instruction is held this cycle |

## Verification
The port booking and the write-after-write check can both trip in the same cycle. This happens when an in-flight write to the same destination lands exactly in the new instruction's write-back slot; divider busy and a source dependence can also coincide. The bench provokes these overlaps with a long random run over only eight registers, next to directed sequences for each hazard alone. It judges every cycle against a model kept in absolute cycle numbers: the write cycle of each register, the owner cycle of each port slot and the last divide start.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    typedef enum logic [2:0] {
        UNIT_INT  = 3'd0,
        UNIT_LOAD = 3'd1,
        UNIT_FADD = 3'd2,
        UNIT_FMUL = 3'd3,
        UNIT_FDIV = 3'd4
    } unit_e;

    typedef struct packed {
        logic writes_fp;
        logic reads_fp;
        logic is_div;
    } op_class_t;

    function automatic op_class_t classify(input logic [2:0] code);
        op_class_t c;
        c = '0;
        case (code)
            UNIT_LOAD: c.writes_fp = 1'b1;
            UNIT_FADD,
            UNIT_FMUL: begin
                c.writes_fp = 1'b1;
                c.reads_fp  = 1'b1;
            end
            UNIT_FDIV: begin
                c.writes_fp = 1'b1;
                c.reads_fp  = 1'b1;
                c.is_div    = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/hzd_scoreboard.sv
module hzd_scoreboard #(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 5,
    parameter int CNT_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic [REG_W-1:0] rd_a,
    input  logic [REG_W-1:0] rd_b,
    input  logic [REG_W-1:0] rd_dst,
    output logic [CNT_W-1:0] cnt_a,
    output logic [CNT_W-1:0] cnt_b,
    output logic [CNT_W-1:0] cnt_dst
);

    typedef struct packed {
        logic [NUM_REGS-1:0][CNT_W-1:0] cnt;
    } sb_state_t;

    sb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (st_q.cnt[i] != '0) begin
                st_d.cnt[i] = st_q.cnt[i] - 1'b1;
            end
        end
        if (we) begin
            st_d.cnt[wr_idx] = wr_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_a   = st_q.cnt[rd_a];
    assign cnt_b   = st_q.cnt[rd_b];
    assign cnt_dst = st_q.cnt[rd_dst];

    // R6
    waw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (st_q.cnt[wr_idx] <= wr_cnt));

endmodule

// File: rtl/hzd_wport.sv
module hzd_wport #(
    parameter int DEPTH  = 24,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot,
    input  logic              book,
    output logic              taken
);

    typedef struct packed {
        logic [DEPTH-1:0] res;
    } wp_state_t;

    wp_state_t st_d, st_q;

    always_comb begin
        st_d.res = st_q.res >> 1;
        if (book) begin
            st_d.res[slot - 1'b1] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign taken = st_q.res[slot];

    // R5
    port_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        book |-> !st_q.res[slot]);

    // R5
    slot_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        book |-> (slot != '0));

endmodule

// File: rtl/hzd_div_track.sv
module hzd_div_track #(
    parameter int DIV_II = 24,
    parameter int DIV_W  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    typedef struct packed {
        logic [DIV_W-1:0] left;
    } dv_state_t;

    dv_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.left = DIV_W'(DIV_II - 1);
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.left != '0);

    // R4
    div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (st_q.left == '0));

endmodule

// File: rtl/hzd_issue_gate.sv
module hzd_issue_gate #(
    parameter int NUM_REGS = 32,
    parameter int LAT_LOAD = 1,
    parameter int LAT_FADD = 3,
    parameter int LAT_FMUL = 6,
    parameter int LAT_FDIV = 23,
    parameter int DIV_II   = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dec_valid,
    input  logic [2:0] dec_unit,
    input  logic [4:0] dec_dst,
    input  logic [4:0] dec_src_a,
    input  logic [4:0] dec_src_b,
    output logic       issue,
    output logic       stall
);
    import hzd_pkg::*;

    localparam int MAX_LAT = max4(LAT_LOAD, LAT_FADD, LAT_FMUL, LAT_FDIV);
    localparam int DEPTH   = MAX_LAT + 1;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);
    localparam int SLOT_W  = $clog2(DEPTH);
    localparam int REG_W   = 5;
    localparam int DIV_W   = $clog2(DIV_II);

    op_class_t        cls;
    logic [CNT_W-1:0] lat_sel;
    logic [CNT_W-1:0] cnt_a, cnt_b, cnt_dst;
    logic             port_taken, div_busy;
    logic             hz_raw, hz_waw, hz_port, hz_div, hazard, go;

    always_comb begin
        cls = classify(dec_unit);
        case (dec_unit)
            UNIT_LOAD: lat_sel = CNT_W'(LAT_LOAD);
            UNIT_FADD: lat_sel = CNT_W'(LAT_FADD);
            UNIT_FMUL: lat_sel = CNT_W'(LAT_FMUL);
            UNIT_FDIV: lat_sel = CNT_W'(LAT_FDIV);
            default:   lat_sel = '0;
        endcase
        hz_raw  = cls.reads_fp  && ((cnt_a != '0) || (cnt_b != '0));
        hz_waw  = cls.writes_fp && (cnt_dst > lat_sel);
        hz_port = cls.writes_fp && port_taken;
        hz_div  = cls.is_div    && div_busy;
        hazard  = hz_raw || hz_waw || hz_port || hz_div;
        go      = dec_valid && !hazard;
    end

    assign issue = go;
    assign stall = dec_valid && hazard;

    hzd_scoreboard #(
        .NUM_REGS(NUM_REGS),
        .REG_W   (REG_W),
        .CNT_W   (CNT_W)
    ) u_sb (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (go && cls.writes_fp),
        .wr_idx (dec_dst),
        .wr_cnt (lat_sel),
        .rd_a   (dec_src_a),
        .rd_b   (dec_src_b),
        .rd_dst (dec_dst),
        .cnt_a  (cnt_a),
        .cnt_b  (cnt_b),
        .cnt_dst(cnt_dst)
    );

    hzd_wport #(
        .DEPTH (DEPTH),
        .SLOT_W(SLOT_W)
    ) u_wp (
        .clk  (clk),
        .rst_n(rst_n),
        .slot (SLOT_W'(lat_sel)),
        .book (go && cls.writes_fp),
        .taken(port_taken)
    );

    hzd_div_track #(
        .DIV_II(DIV_II),
        .DIV_W (DIV_W)
    ) u_dv (
        .clk  (clk),
        .rst_n(rst_n),
        .start(go && cls.is_div),
        .busy (div_busy)
    );

    // R1
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue && stall) && ((issue || stall) == dec_valid));

    // R2
    int_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !cls.writes_fp && !cls.reads_fp) |-> issue);

    // R3
    raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && cls.reads_fp) |-> ((cnt_a == '0) && (cnt_b == '0)));

    // R4
    div_ii_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_unit == 3'd4) |=> !(issue && dec_unit == 3'd4));

endmodule

// File: tb/sim_hzd_issue_gate.sv
module sim_hzd_issue_gate;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dec_valid = 1'b0;
    logic [2:0] dec_unit = '0;
    logic [4:0] dec_dst = '0, dec_src_a = '0, dec_src_b = '0;
    logic       issue, stall;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int wb_at[32];
    int port_at[64];
    int last_div;

    always #5 clk = ~clk;

    hzd_issue_gate u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec_valid(dec_valid),
        .dec_unit (dec_unit),
        .dec_dst  (dec_dst),
        .dec_src_a(dec_src_a),
        .dec_src_b(dec_src_b),
        .issue    (issue),
        .stall    (stall)
    );

    function automatic int lat_of(int u);
        case (u)
            1: return 1;
            2: return 3;
            3: return 6;
            4: return 23;
            default: return 0;
        endcase
    endfunction

    function automatic bit hazard_of(int t, int u, int d, int a, int b);
        int l;
        if (u < 1 || u > 4) return 1'b0;
        l = lat_of(u);
        if (u >= 2 && (t <= wb_at[a] || t <= wb_at[b])) return 1'b1;
        if (u == 4 && t < last_div + 24) return 1'b1;
        if (port_at[(t + l) % 64] == t + l) return 1'b1;
        if (wb_at[d] >= t + l) return 1'b1;
        return 1'b0;
    endfunction

    task automatic step(bit v, int u, int d, int a, int b, string tag);
        bit h, e_iss, e_st;
        int l;
        @(negedge clk);
        dec_valid = v;
        dec_unit  = 3'(u);
        dec_dst   = 5'(d);
        dec_src_a = 5'(a);
        dec_src_b = 5'(b);
        #1;
        h     = v && hazard_of(cyc, u, d, a, b);
        e_iss = v && !h;
        e_st  = h;
        checks++;
        if (issue !== e_iss || stall !== e_st) begin
            fails++;
            $display("FAIL %s cycle %0d unit %0d: issue/stall actual %b%b expected %b%b",
                     tag, cyc, u, issue, stall, e_iss, e_st);
        end
        if (e_iss && u >= 1 && u <= 4) begin
            l = lat_of(u);
            wb_at[d] = cyc + l;
            port_at[(cyc + l) % 64] = cyc + l;
            if (u == 4) last_div = cyc;
        end
        cyc++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0, 0, "R1");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) wb_at[i] = -100;
        for (int i = 0; i < 64; i++) port_at[i] = -1;
        last_div = -100;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: quiet outputs, then first divide issues at once
        step(1'b0, 4, 9, 0, 0, "R8");
        step(1'b1, 4, 9, 0, 0, "R8");
        // R2: integer and unused codes pass while divider busy
        step(1'b1, 0, 9, 9, 9, "R2");
        step(1'b1, 6, 9, 9, 9, "R2");
        step(1'b1, 7, 3, 9, 9, "R2");
        idle(40);

        // R3: dependent add waits three cycles
        step(1'b1, 2, 1, 0, 0, "R3");
        repeat (4) step(1'b1, 2, 2, 1, 0, "R3");
        idle(10);

        // R4: second divide waits 23 cycles
        step(1'b1, 4, 3, 0, 0, "R4");
        repeat (24) step(1'b1, 4, 4, 0, 0, "R4");
        idle(40);

        // R5: add landing on the multiply's write cycle
        step(1'b1, 3, 5, 0, 0, "R5");
        step(1'b1, 0, 0, 0, 0, "R5");
        step(1'b1, 0, 0, 0, 0, "R5");
        repeat (2) step(1'b1, 2, 6, 0, 0, "R5");
        idle(10);

        // R6: load to the multiply's destination waits
        step(1'b1, 3, 7, 0, 0, "R6");
        repeat (6) step(1'b1, 1, 7, 0, 0, "R6");
        idle(10);

        // R7: back-to-back pipelined ops
        step(1'b1, 2, 8, 0, 0, "R7");
        step(1'b1, 2, 9, 0, 0, "R7");
        step(1'b1, 3, 10, 0, 0, "R7");
        step(1'b1, 3, 11, 0, 0, "R7");
        idle(30);

        // R9: a stalled divide leaves no trace
        step(1'b1, 4, 17, 0, 0, "R9");
        step(1'b1, 4, 18, 0, 0, "R9");
        step(1'b1, 2, 19, 18, 0, "R9");
        idle(40);

        // R1: random mix over eight registers
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 4) != 0, int'($urandom % 8), int'($urandom % 8),
                 int'($urandom % 8), int'($urandom % 8), "R1");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule